// File: doc/BRIEF.md
# VFD Grid Scan and Dimming Timer

This block generates the time-multiplexed drive pattern for a vacuum-fluorescent display with two or three grids and 32 anodes. A bit time is a fixed number of oscillator clocks, and each grid owns a slot of 1024 bit times. Inside its slot a grid is switched on for a number of bit times set by a 10-bit brightness value. A segment enable window, slightly longer than the grid pulse, gates the 32 segment outputs. The segment outputs show the stored word that belongs to the grid currently being scanned.

As a master the block runs its own scan. It exports the enable window and a 2-bit latch-select code, so that a second device can follow the same scan and drive more anodes. As a follower it has no timing of its own. It picks a stored word from the two select inputs, gates it with the incoming window, and holds its grid, window and select outputs low. Grid outputs are active-low, because an external pre-driver inverts them.

Top module: `vfd_scan_timer`

## Requirements
- R1: One bit time is 4 clock cycles and a slot is 1024 bit times. Slots run in the order grid 1, grid 2, grid 3 (triplex) and then return to grid 1. Only the grid of the current slot can be on, and only inside that slot.
- R2: With `tri_sel` = 0 the scan uses two slots, and `grid_n[2]` stays high in master mode. With `tri_sel` = 1 the scan uses three slots.
- R3: The duty is the brightness value, capped at 1016. In master mode `grid_n[k]` is low (on) for the first duty bit times of slot k and high for the rest of that slot.
- R4: When the duty is not zero, the enable window (and `dim_out`) is high for the first duty+3 bit times of every slot and low for the rest. At duty 1016 this gives 1019 bit times high and 5 bit times low.
- R5: In master mode `seg_out[i]` is bit i of the current slot's word (`lat_a`, `lat_b`, `lat_c` for slots 1, 2, 3), ANDed with the enable window.
- R6: In master mode (`sync_out1`, `sync_out2`) carries (0,0) in slot 1, (1,0) in slot 2 and (0,1) in slot 3.
- R7: In master mode `sync_in1`, `sync_in2` and `dim_in` have no effect on any output.
- R8: In slave mode `seg_out` one clock after the inputs equals the word chosen by (`sync_in1`,`sync_in2`), ANDed with `dim_in`. The code (0,0) selects `lat_a`, (1,0) selects `lat_b`, (0,1) selects `lat_c`, and (1,1) selects no word, so all segments are low.
- R9: In slave mode `grid_n`, `dim_out`, `sync_out1` and `sync_out2` are all low.
- R10: During reset, all segments, `dim_out` and both sync outputs are low. `grid_n` is all high in master mode and all low in slave mode. After release the scan starts at bit 0 of slot 1. Outputs are registered, so they lag the scan position by one clock.
- R11: A brightness value of 0 lights no grid and no segment, and keeps `dim_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dim_level | input | 10 | Brightness value (duty in bit times, capped at 1016) |
| lat_a | input | 32 | Segment word for grid 1 |
| lat_b | input | 32 | Segment word for grid 2 |
| lat_c | input | 32 | Segment word for grid 3 |
| tri_sel | input | 1 | 1 = three-grid scan, 0 = two-grid scan |
| master_sel | input | 1 | 1 = master, 0 = follower |
| sync_in1 | input | 1 | Follower latch-select bit 1 |
| sync_in2 | input | 1 | Follower latch-select bit 2 |
| dim_in | input | 1 | Follower enable window |
| grid_n | output | 3 | Active-low grid drive |
| seg_out | output | 32 | Segment drive, high = lit |
| dim_out | output | 1 | Exported enable window |
| sync_out1 | output | 1 | Exported latch-select bit 1 |
| sync_out2 | output | 1 | Exported latch-select bit 2 |

## Verification
The master scan is compared clock by clock over a full frame plus part of the next, for several cases:
- the full duty in both the two-grid and the three-grid scan, which separates the grid-off gap from the shorter window blank and checks the slot wrap;
- a value above the cap, which exercises clamping;
- zero and one, which separate an empty pulse from the shortest one;
- a mid value.

In some master cases the follower inputs toggle constantly, to show that they are ignored. The follower checks walk all four select codes with the window high and low, and include a long stretch of scanning during which the exported outputs must stay quiet.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  // Latch select code {sync2, sync1}; equals the slot index in master mode
  typedef enum logic [1:0] {
    LSEL_1    = 2'b00,
    LSEL_2    = 2'b01,
    LSEL_3    = 2'b10,
    LSEL_NONE = 2'b11
  } lsel_e;
endpackage

// File: rtl/vfd_scan_counter.sv
module vfd_scan_counter #(
  parameter int BIT_DIV   = 4,
  parameter int SLOT_BITS = 1024,
  localparam int PH_W = $clog2(BIT_DIV),
  localparam int BI_W = $clog2(SLOT_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tri_sel,
  output logic [BI_W-1:0] bit_idx,
  output logic [1:0]      slot_idx
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic [BI_W-1:0] bit_q, bit_d;
  logic [1:0]      slot_q, slot_d, last_slot;
  logic            bit_ce, slot_ce;

  always_comb begin
    bit_ce    = (ph_q == PH_W'(BIT_DIV - 1));
    slot_ce   = bit_ce && (bit_q == BI_W'(SLOT_BITS - 1));
    last_slot = tri_sel ? 2'd2 : 2'd1;
    ph_d      = bit_ce ? '0 : ph_q + 1'b1;
    bit_d     = bit_q;
    if (bit_ce) bit_d = slot_ce ? '0 : bit_q + 1'b1;
    slot_d    = slot_q;
    if (slot_ce) slot_d = (slot_q >= last_slot) ? 2'd0 : slot_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign bit_idx  = bit_q;
  assign slot_idx = slot_q;

  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != 2'b11);  // R1
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != $past(slot_q)) |->
      ($past(bit_q) == BI_W'(SLOT_BITS - 1) && $past(ph_q) == PH_W'(BIT_DIV - 1)));  // R1
endmodule

// File: rtl/vfd_pulse_gen.sv
module vfd_pulse_gen #(
  parameter int DIM_W   = 10,
  parameter int DIM_MAX = 1016,
  parameter int GUARD   = 3,
  parameter int BI_W    = 10,
  localparam int CW = ((BI_W > DIM_W) ? BI_W : DIM_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] dim_level,
  input  logic [BI_W-1:0]  bit_idx,
  output logic             grid_act,
  output logic             win_act
);
  logic [DIM_W-1:0] duty;
  logic [CW-1:0]    bit_x, duty_x;

  always_comb begin
    duty     = (dim_level > DIM_W'(DIM_MAX)) ? DIM_W'(DIM_MAX) : dim_level;
    bit_x    = CW'(bit_idx);
    duty_x   = CW'(duty);
    grid_act = bit_x < duty_x;
    win_act  = (duty != '0) && (bit_x < duty_x + CW'(GUARD));
  end

  AST_GRID_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    grid_act |-> win_act);  // R4
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    grid_act |-> (bit_x < CW'(DIM_MAX)));  // R3
endmodule

// File: rtl/vfd_seg_out.sv
module vfd_seg_out
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int NGRID = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        master_sel,
  input  logic [1:0]                  slot_idx,
  input  logic                        grid_act,
  input  logic                        win_act,
  input  logic                        sync_in1,
  input  logic                        sync_in2,
  input  logic                        dim_in,
  input  logic [NGRID-1:0][SEG_W-1:0] lat_words,
  output logic [NGRID-1:0]            grid_q,
  output logic [SEG_W-1:0]            seg_q,
  output logic                        dim_q,
  output logic [1:0]                  sync_q
);
  lsel_e             sel;
  logic              gate;
  logic [SEG_W-1:0]  word, seg_d;
  logic [NGRID-1:0]  grid_d;
  logic              dim_d;
  logic [1:0]        sync_d;

  always_comb begin
    sel  = master_sel ? lsel_e'(slot_idx) : lsel_e'({sync_in2, sync_in1});
    gate = master_sel ? win_act : dim_in;
    word = '0;
    for (int i = 0; i < NGRID; i++) begin
      if (sel == lsel_e'(2'(i))) word = lat_words[i];
    end
    seg_d = gate ? word : '0;
    for (int i = 0; i < NGRID; i++) begin
      grid_d[i] = master_sel && grid_act && (slot_idx == 2'(i));
    end
    dim_d  = master_sel && win_act;
    sync_d = master_sel ? slot_idx : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid_q <= '0;
      seg_q  <= '0;
      dim_q  <= 1'b0;
      sync_q <= 2'b00;
    end else begin
      grid_q <= grid_d;
      seg_q  <= seg_d;
      dim_q  <= dim_d;
      sync_q <= sync_d;
    end
  end

  AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_q));  // R1
  AST_SEG_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|seg_q) |-> $past(gate));  // R5
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master_sel) |-> (grid_q == '0 && !dim_q && sync_q == 2'b00));  // R9
endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer #(
  parameter int BIT_DIV   = 4,
  parameter int SLOT_BITS = 1024,
  parameter int DIM_W     = 10,
  parameter int DIM_MAX   = 1016,
  parameter int GUARD     = 3,
  parameter int SEG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] dim_level,
  input  logic [SEG_W-1:0] lat_a,
  input  logic [SEG_W-1:0] lat_b,
  input  logic [SEG_W-1:0] lat_c,
  input  logic             tri_sel,
  input  logic             master_sel,
  input  logic             sync_in1,
  input  logic             sync_in2,
  input  logic             dim_in,
  output logic [2:0]       grid_n,
  output logic [SEG_W-1:0] seg_out,
  output logic             dim_out,
  output logic             sync_out1,
  output logic             sync_out2
);
  localparam int NGRID = 3;
  localparam int BI_W  = $clog2(SLOT_BITS);

  logic [BI_W-1:0]             bit_idx;
  logic [1:0]                  slot_idx;
  logic                        grid_act, win_act;
  logic [NGRID-1:0][SEG_W-1:0] lat_words;
  logic [NGRID-1:0]            grid_q;
  logic [1:0]                  sync_q;

  assign lat_words = {lat_c, lat_b, lat_a};

  vfd_scan_counter #(.BIT_DIV(BIT_DIV), .SLOT_BITS(SLOT_BITS)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tri_sel(tri_sel),
    .bit_idx(bit_idx), .slot_idx(slot_idx)
  );

  vfd_pulse_gen #(.DIM_W(DIM_W), .DIM_MAX(DIM_MAX), .GUARD(GUARD), .BI_W(BI_W)) i_pulse (
    .clk(clk), .rst_n(rst_n), .dim_level(dim_level), .bit_idx(bit_idx),
    .grid_act(grid_act), .win_act(win_act)
  );

  vfd_seg_out #(.SEG_W(SEG_W), .NGRID(NGRID)) i_seg (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .slot_idx(slot_idx),
    .grid_act(grid_act), .win_act(win_act), .sync_in1(sync_in1),
    .sync_in2(sync_in2), .dim_in(dim_in), .lat_words(lat_words),
    .grid_q(grid_q), .seg_q(seg_out), .dim_q(dim_out), .sync_q(sync_q)
  );

  // Active-low grids: idle high as master, forced low as follower
  assign grid_n    = master_sel ? ~grid_q : '0;
  assign sync_out1 = sync_q[0];
  assign sync_out2 = sync_q[1];

  AST_DUPLEX_G3_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !tri_sel && $past(!tri_sel) && slot_idx != 2'd2) |=> grid_n[2]);  // R2
endmodule

// File: tb/test_vfd_scan_timer.sv
`timescale 1ns/1ps
module test_vfd_scan_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  dim_level;
  logic [31:0] lat_a, lat_b, lat_c;
  logic        tri_sel, master_sel, sync_in1, sync_in2, dim_in;
  logic [2:0]  grid_n;
  logic [31:0] seg_out;
  logic        dim_out, sync_out1, sync_out2;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vfd_scan_timer i_vfd_scan_timer (
    .clk(clk), .rst_n(rst_n), .dim_level(dim_level), .lat_a(lat_a), .lat_b(lat_b),
    .lat_c(lat_c), .tri_sel(tri_sel), .master_sel(master_sel), .sync_in1(sync_in1),
    .sync_in2(sync_in2), .dim_in(dim_in), .grid_n(grid_n), .seg_out(seg_out),
    .dim_out(dim_out), .sync_out1(sync_out1), .sync_out2(sync_out2)
  );

  // Vector: [11] tri_sel, [10:1] brightness, [0] toggle follower inputs
  localparam logic [11:0] VEC [6] = '{
    {1'b1, 10'd1016, 1'b0},
    {1'b0, 10'd1016, 1'b1},
    {1'b1, 10'd0,    1'b0},
    {1'b1, 10'd1023, 1'b1},
    {1'b0, 10'd1,    1'b0},
    {1'b1, 10'd500,  1'b1}
  };

  task automatic check(input string req, input logic [37:0] got, input logic [37:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Expected master output {grid_n, seg_out, dim_out, sync1, sync2} at scan position p
  function automatic logic [37:0] model(input logic tri_m, input int dim,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input int p);
    int bt, sl, d;
    logic g, w;
    logic [2:0] gn;
    logic [31:0] wd;
    bt = (p / 4) % 1024;
    sl = (p / 4096) % (tri_m ? 3 : 2);
    d  = (dim > 1016) ? 1016 : dim;
    g  = bt < d;
    w  = (d != 0) && (bt < d + 3);
    gn = 3'b111;
    if (g) gn[sl] = 1'b0;
    wd = (sl == 0) ? a : (sl == 1) ? b : c;
    return {gn, (w ? wd : 32'h0), w, (sl == 1), (sl == 2)};
  endfunction

  function automatic logic [37:0] outs();
    return {grid_n, seg_out, dim_out, sync_out1, sync_out2};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_520_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dim_level = '0; lat_a = '0; lat_b = '0; lat_c = '0;
    tri_sel = 1'b1; master_sel = 1'b1; sync_in1 = 1'b0; sync_in2 = 1'b0; dim_in = 1'b0;

    // Table-driven master runs
    for (int v = 0; v < 6; v++) begin
      logic tri_v, noise;
      int dim_v, cyc;
      tri_v = VEC[v][11];
      dim_v = int'(VEC[v][10:1]);
      noise = VEC[v][0];
      tri_sel = tri_v; dim_level = VEC[v][10:1]; master_sel = 1'b1;
      lat_a = 32'hA5C3_0F01 ^ (32'(v) << 4);
      lat_b = 32'h5A3C_F0E2 ^ 32'(v);
      lat_c = 32'h1248_8421 + 32'(v);
      do_reset();
      // R10: master reset state
      check("R10 master reset", outs(), {3'b111, 32'h0, 1'b0, 1'b0, 1'b0});
      rst_n = 1'b1;
      cyc = (tri_v ? 3 : 2) * 4096 + 100;
      for (int k = 1; k <= cyc; k++) begin
        @(posedge clk);
        @(negedge clk);
        // R1 R2 R3 R4 R5 R6 R7 R11 against the scan model at position k-1
        check(dim_v == 0 ? "R11" : (noise ? "R7" : "R1-scan R3 R4 R5 R6"),
              outs(), model(tri_v, dim_v, lat_a, lat_b, lat_c, k - 1));
        if (noise) begin
          sync_in1 = ~sync_in1;
          sync_in2 = (k % 3) == 0;
          dim_in   = (k % 5) < 2;
        end
      end
      sync_in1 = 1'b0; sync_in2 = 1'b0; dim_in = 1'b0;
    end

    // Follower directed tests
    master_sel = 1'b0; tri_sel = 1'b1; dim_level = 10'd1016;
    lat_a = 32'hDEAD_BEEF; lat_b = 32'h0123_4567; lat_c = 32'hF0F0_3C3C;
    do_reset();
    check("R10 slave reset", outs(), 38'h0);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      logic [31:0] ew;
      sync_in1 = s[0]; sync_in2 = s[1]; dim_in = s[2];
      @(posedge clk);
      @(negedge clk);
      ew = (s[1:0] == 2'b00) ? lat_a : (s[1:0] == 2'b01) ? lat_b :
           (s[1:0] == 2'b10) ? lat_c : 32'h0;
      check("R8 slave select", {32'h0, seg_out}, {32'h0, (s[2] ? ew : 32'h0)});
    end
    sync_in1 = 1'b1; sync_in2 = 1'b0; dim_in = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9 slave quiet", {grid_n, dim_out, sync_out1, sync_out2, seg_out},
            {3'b000, 1'b0, 1'b0, 1'b0, lat_b});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule